// File: doc/BRIEF.md
# Age-Bit Pseudo-LRU Victim Selector

This block picks the way to evict from one set of a set-associative cache. It holds one age flag per way. Each hit strobe fills the next flag upward, so the flags always read as a thermometer code. The way to replace is the lowest-numbered way whose flag is still clear. When a hit arrives with the highest flag already set, the whole vector empties and the fill starts again from way 0.

The flags are built as J/K-style set/clear cells. Each cell's set input comes from the flag just below it. Every clear input is tied to the top flag, except the top cell's own clear input, which is always enabled. Selection is a prefix chain. The chain marks a way when all flags beneath it are set and its own flag is clear. When every flag is set, the top way is chosen, so the select output stays one-hot. The flag vector is also driven on a port, so that the surrounding cache logic can observe it.

Top module: `plru_age_victim`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every age flag, so way 0 is the victim in the following cycle. Reset takes priority over a simultaneous hit.
- R2: A hit from the empty vector sets flag 0 only.
- R3: A hit while the top flag is clear sets the lowest clear flag and leaves every other flag unchanged. After k hits from empty (k < WAYS), flags 0..k-1 are set and all others are clear.
- R4: A hit while the top flag (bit WAYS-1) is set clears all WAYS flags at the next edge.
- R5: While `hit` is low and `rst` is low, the flag vector holds its value.
- R6: When at least one flag is clear, the victim is the lowest index whose flag is clear: its own flag is 0 and every flag below it is 1.
- R7: When all flags are set, the victim is way WAYS-1.
- R8: `victim_oh` always has exactly one bit set, and `victim_idx` is the binary position of that bit (bit i of `victim_oh` corresponds to index i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hit | input | 1 | Hit strobe for this set; advances the fill by one flag |
| age_q | output | WAYS | Age flags, bit i belonging to way i |
| victim_oh | output | WAYS | One-hot replacement select |
| victim_idx | output | $clog2(WAYS) | Binary index of the replacement way |

## Verification
The bench builds four copies of the block side by side, with WAYS set to 4, 8, 16 and 32. All four receive the same hit and reset stream. Because the fill period is WAYS+1 hits, one stream drives each copy through several full wrap-arounds, including the all-set state and its bulk clear. The copies reach these states at different times, so the stream also lands a reset in the middle of a fill for each width. The wider copies exercise the longer prefix chains, and the 32-way copy exercises a 5-bit index.

// File: rtl/plru_age_pkg.sv
package plru_age_pkg;
  // Width of a binary way index, never below one bit.
  function automatic int unsigned idx_width(input int unsigned ways);
    return (ways < 2) ? 1 : $clog2(ways);
  endfunction

  // Next value of a J/K set/clear element.
  function automatic logic jk_next(input logic j, input logic k, input logic q);
    return (j & ~q) | (~k & q);
  endfunction
endpackage

// File: rtl/plru_age_cell.sv
module plru_age_cell
  import plru_age_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_en,
  input  logic clr_en,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= jk_next(set_en, clr_en, q);
  end
endmodule

// File: rtl/plru_age_vector.sv
module plru_age_vector #(
  parameter int unsigned WAYS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hit,
  output logic [WAYS-1:0] age
);
  localparam int unsigned TOP = WAYS - 1;

  logic [WAYS-1:0] set_en;
  logic [WAYS-1:0] clr_en;

  for (genvar n = 0; n < WAYS; n++) begin : g_cell
    if (n == 0) begin : g_first
      assign set_en[n] = hit;
      assign clr_en[n] = hit & age[TOP];
    end else if (n == TOP) begin : g_top
      assign set_en[n] = hit & age[n-1];
      assign clr_en[n] = hit;
    end else begin : g_mid
      assign set_en[n] = hit & age[n-1];
      assign clr_en[n] = hit & age[TOP];
    end
    plru_age_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .set_en(set_en[n]),
      .clr_en(clr_en[n]),
      .q     (age[n])
    );
  end
endmodule

// File: rtl/plru_victim_chain.sv
module plru_victim_chain #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [WAYS-1:0]  age,
  output logic [WAYS-1:0]  sel_oh,
  output logic [IDX_W-1:0] sel_idx,
  output logic             all_set
);
  // below_full[n] is high when flags 0..n-1 are all set.
  logic [WAYS:0] below_full;
  assign below_full[0] = 1'b1;

  for (genvar n = 0; n < WAYS; n++) begin : g_link
    assign below_full[n+1] = below_full[n] & age[n];
    if (n == WAYS - 1) begin : g_last
      assign sel_oh[n] = below_full[n];
    end else begin : g_body
      assign sel_oh[n] = below_full[n] & ~age[n];
    end
  end

  assign all_set = below_full[WAYS];

  function automatic logic [IDX_W-1:0] encode(input logic [WAYS-1:0] oh);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (oh[i]) r = r | IDX_W'(i);
    end
    return r;
  endfunction

  assign sel_idx = encode(sel_oh);
endmodule

// File: rtl/plru_age_victim.sv
module plru_age_victim
  import plru_age_pkg::*;
#(
  parameter int unsigned WAYS  = 8,
  localparam int unsigned IDX_W = idx_width(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  output logic [WAYS-1:0]  age_q,
  output logic [WAYS-1:0]  victim_oh,
  output logic [IDX_W-1:0] victim_idx
);
  logic all_set;

  plru_age_vector #(.WAYS(WAYS)) u_vec (
    .clk(clk),
    .rst(rst),
    .hit(hit),
    .age(age_q)
  );

  plru_victim_chain #(.WAYS(WAYS), .IDX_W(IDX_W)) u_chain (
    .age    (age_q),
    .sel_oh (victim_oh),
    .sel_idx(victim_idx),
    .all_set(all_set)
  );
endmodule

// File: rtl/plru_age_victim_chk.sv
module plru_age_victim_chk #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             hit,
  input logic [WAYS-1:0]  age_q,
  input logic [WAYS-1:0]  victim_oh,
  input logic [IDX_W-1:0] victim_idx,
  input logic             all_set
);
  logic [WAYS-1:0] filled_one_more;
  assign filled_one_more = {age_q[WAYS-2:0], 1'b1};

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (age_q == '0) && (victim_idx == '0));

  assert_first_fill_R2: assert property (@(posedge clk) disable iff (rst)
    (hit && age_q == '0) |=> age_q[0] && ($countones(age_q) == 1));

  assert_fill_step_R3: assert property (@(posedge clk) disable iff (rst)
    (hit && !age_q[WAYS-1]) |=> age_q == $past(filled_one_more));

  assert_bulk_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (hit && age_q[WAYS-1]) |=> age_q == '0);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(age_q));

  assert_first_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (age_q != '1) |-> (((victim_oh & age_q) == '0) &&
                       (((victim_oh - 1'b1) & ~age_q) == '0)));

  assert_full_top_R7: assert property (@(posedge clk) disable iff (rst)
    all_set |-> victim_oh[WAYS-1]);

  assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    ($countones(victim_oh) == 1) && victim_oh[victim_idx]);
endmodule

bind plru_age_victim plru_age_victim_chk #(.WAYS(WAYS), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hit       (hit),
  .age_q     (age_q),
  .victim_oh (victim_oh),
  .victim_idx(victim_idx),
  .all_set   (all_set)
);

// File: tb/plru_age_victim_bench.sv
module plru_age_victim_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hit = 1'b0;
  logic running = 1'b0;
  int   n_checks = 0;
  int   n_fail = 0;

  always #4 clk = ~clk;

  localparam int NW = 4;
  localparam int WS [NW] = '{4, 8, 16, 32};

  for (genvar gi = 0; gi < NW; gi++) begin : g_dut
    localparam int W  = WS[gi];
    localparam int IW = $clog2(W);

    logic [W-1:0]  age_q;
    logic [W-1:0]  victim_oh;
    logic [IW-1:0] victim_idx;

    plru_age_victim #(.WAYS(W)) u_plru_age_victim (
      .clk       (clk),
      .rst       (rst),
      .hit       (hit),
      .age_q     (age_q),
      .victim_oh (victim_oh),
      .victim_idx(victim_idx)
    );

    // Reference: a fill count 0..W; the flags are its thermometer image.
    int cnt = 0;
    int prev_cnt = 0;
    logic last_rst = 1'b1;
    logic last_hit = 1'b0;

    always @(posedge clk) begin
      prev_cnt = cnt;
      last_rst = rst;
      last_hit = hit;
      if (rst)      cnt = 0;
      else if (hit) cnt = (cnt == W) ? 0 : cnt + 1;
    end

    always @(negedge clk) begin
      if (running) begin
        longint exp_age;
        int     exp_idx;
        string  tag;
        exp_age = (longint'(1) << cnt) - 1;
        exp_idx = (cnt == W) ? W - 1 : cnt;
        if (last_rst)                     tag = "R1";
        else if (!last_hit)               tag = "R5";
        else if (prev_cnt == W)           tag = "R4";
        else if (prev_cnt == 0)           tag = "R2";
        else                              tag = "R3";
        n_checks++;
        if (longint'(age_q) != exp_age) begin
          n_fail++;
          $display("FAIL %s W=%0d age actual=%h expected=%h", tag, W, age_q, exp_age);
        end
        n_checks++;
        if (int'(victim_idx) != exp_idx) begin
          n_fail++;
          $display("FAIL %s W=%0d victim_idx actual=%0d expected=%0d",
                   (cnt == W) ? "R7" : "R6", W, victim_idx, exp_idx);
        end
        n_checks++;
        if (longint'(victim_oh) != (longint'(1) << exp_idx)) begin
          n_fail++;
          $display("FAIL R8 W=%0d victim_oh actual=%h expected=%h",
                   W, victim_oh, longint'(1) << exp_idx);
        end
      end
    end
  end

  task automatic step(input logic h, input logic r);
    @(negedge clk);
    hit = h;
    rst = r;
  endtask

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    repeat (3) step(1'b0, 1'b1);
    running = 1'b1;
    step(1'b0, 1'b0);
    // Continuous hits: several wraps for every width.
    for (int i = 0; i < 80; i++) step(1'b1, 1'b0);
    // Alternating hits and idle cycles.
    for (int i = 0; i < 70; i++) step(i[0], 1'b0);
    // Pseudo-random hit pattern.
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] | lfsr[2], 1'b0);
    end
    // Reset arriving with a hit, mid-fill.
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 100; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    running = 1'b0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule